// File: doc/BRIEF.md
# Edge-to-Pulse Encoder with Timed Refresh

This block sits on the transmit side of one isolated logic channel. It samples a slow logic input on a fast system clock, removes short glitches, and turns every accepted transition into a single-cycle event pulse. A rising transition pulses the set line and a falling transition pulses the clear line. The receiver across the barrier keeps only a latch, so it has no timeout of its own.

When the input stays quiet for a full idle interval, the block resends the present level on the matching line. It then repeats this at a fixed refresh period, so a receiver that missed a pulse or has just powered up recovers the correct level. Right after reset one pulse for the current level goes out. Each accepted edge restarts the idle interval.

The input is a plain level, not a stream. Both outputs are fire-and-forget strobes with no valid/ready handshake and no back-pressure. The receiver must capture each strobe in the cycle it appears. All timing values are parameters in clock cycles: `SYNC_STAGES` (2), `GLITCH_CYCLES` (4), `IDLE_CYCLES` (100) and `REFRESH_CYCLES` (85).

Top module: `edge_pulse_tx`

## Requirements
- R1: While `rst_n` is low both outputs are low. In the first cycle after the first clock edge with `rst_n` high, exactly one pulse for the accepted level is sent. That level is 0 after reset, so the pulse is on `rst_o`.
- R2: Let edge k be the first clock edge that samples `din_i` at a new high level, and let the level hold for `GLITCH_CYCLES` sampling edges. Then `set_o` is high for one cycle, in the cycle after edge k+`SYNC_STAGES`+`GLITCH_CYCLES`-1.
- R3: A falling transition accepted under the same rule as R2 gives a one-cycle `rst_o` pulse with the same latency.
- R4: A new level held for fewer than `GLITCH_CYCLES` sampling edges gives no pulse. Later refresh pulses still carry the old level.
- R5: A new level held for exactly `GLITCH_CYCLES` sampling edges is accepted as an edge.
- R6: The first refresh pulse comes `IDLE_CYCLES` cycles after the latest edge pulse or start pulse. It appears on `set_o` when the accepted level is 1 and on `rst_o` when it is 0.
- R7: While the input stays quiet, further refresh pulses follow every `REFRESH_CYCLES` cycles, each carrying the accepted level.
- R8: An edge pulse that falls in the cycle where a refresh was due replaces that refresh. The idle interval is then timed again from the edge.
- R9: `set_o` and `rst_o` are never high in the same cycle. Every pulse lasts exactly one cycle, and no pulse appears outside the cases of R1 to R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_i | input | 1 | Asynchronous logic level to be carried across the barrier |
| set_o | output | 1 | One-cycle strobe: level is now 1 (edge or refresh) |
| rst_o | output | 1 | One-cycle strobe: level is now 0 (edge or refresh) |

## Verification
Long quiet stretches at each level show that the idle interval and the refresh period are two distinct timers, and that refreshes pick the line from the accepted level. Glitches of both polarities one cycle shorter than the filter length show that rejected activity neither pulses nor changes the refreshed level. A high level held exactly the filter length, followed at once by a fall, shows the acceptance boundary and back-to-back opposite edges. A third edge placed exactly on a due refresh slot shows that the edge wins and that the timer restarts from it.

// File: rtl/edge_pulse_pkg.sv
package edge_pulse_pkg;
  typedef enum logic [1:0] {
    PULSE_NONE = 2'd0,
    PULSE_SET  = 2'd1,
    PULSE_CLR  = 2'd2
  } pulse_e;

  function automatic pulse_e level_pulse(input logic lvl);
    return lvl ? PULSE_SET : PULSE_CLR;
  endfunction
endpackage

// File: rtl/ept_sync.sv
module ept_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ept_glitch_filter.sv
module ept_glitch_filter #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o,
  output logic accept_o
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic [CW-1:0] run_q;
  logic          level_q;
  logic          differ;

  assign differ   = (raw_i != level_q);
  assign accept_o = differ && (run_q == CW'(HOLD - 1));
  assign level_o  = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= 1'b0;
    end else if (!differ) begin
      run_q <= '0;
    end else if (accept_o) begin
      level_q <= raw_i;
      run_q   <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/ept_refresh_timer.sv
module ept_refresh_timer #(
  parameter int IDLE   = 100,
  parameter int PERIOD = 85
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic tick_o
);
  localparam int LIMIT = (IDLE > PERIOD) ? IDLE : PERIOD;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          periodic_q;
  logic [CW-1:0] last;

  assign last   = periodic_q ? CW'(PERIOD - 1) : CW'(IDLE - 1);
  assign tick_o = !kick_i && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      periodic_q <= 1'b0;
    end else if (kick_i) begin
      cnt_q      <= '0;
      periodic_q <= 1'b0;
    end else if (tick_o) begin
      cnt_q      <= '0;
      periodic_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/edge_pulse_tx.sv
module edge_pulse_tx
  import edge_pulse_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int GLITCH_CYCLES  = 4,
  parameter int IDLE_CYCLES    = 100,
  parameter int REFRESH_CYCLES = 85
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic set_o,
  output logic rst_o
);
  logic   sync_q;
  logic   level_q;
  logic   accept;
  logic   tick;
  logic   boot_q;
  pulse_e next_pulse;

  ept_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(din_i), .q_o(sync_q)
  );

  ept_glitch_filter #(.HOLD(GLITCH_CYCLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(sync_q),
    .level_o(level_q), .accept_o(accept)
  );

  ept_refresh_timer #(.IDLE(IDLE_CYCLES), .PERIOD(REFRESH_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick_i(accept | boot_q), .tick_o(tick)
  );

  // An accepted edge outranks the start pulse and any due refresh.
  always_comb begin
    if (accept)              next_pulse = level_pulse(sync_q);
    else if (boot_q || tick) next_pulse = level_pulse(level_q);
    else                     next_pulse = PULSE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      set_o  <= 1'b0;
      rst_o  <= 1'b0;
    end else begin
      boot_q <= 1'b0;
      set_o  <= (next_pulse == PULSE_SET);
      rst_o  <= (next_pulse == PULSE_CLR);
    end
  end
endmodule

// File: rtl/edge_pulse_tx_chk.sv
module edge_pulse_tx_chk #(
  parameter int IDLE_CYCLES    = 100,
  parameter int REFRESH_CYCLES = 85
) (
  input logic clk,
  input logic rst_n,
  input logic set_o,
  input logic rst_o,
  input logic level_q,
  input logic sync_q
);
  localparam int MAXGAP = (IDLE_CYCLES > REFRESH_CYCLES) ? IDLE_CYCLES : REFRESH_CYCLES;
  localparam int GW     = $clog2(MAXGAP + 2);

  logic          first_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      gap_q   <= '0;
    end else begin
      first_q <= 1'b0;
      if (set_o || rst_o)            gap_q <= '0;
      else if (gap_q != GW'(MAXGAP)) gap_q <= gap_q + 1'b1;
    end
  end

  p_start_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |=> (set_o || rst_o));
  p_set_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |-> level_q);
  p_clr_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |-> !level_q);
  p_change_pulsed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> (set_o || rst_o));
  p_filter_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> ($past(sync_q) == level_q));
  p_max_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q < GW'(MAXGAP));
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_o && rst_o));
  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_o || rst_o) |=> !(set_o || rst_o));
endmodule

bind edge_pulse_tx edge_pulse_tx_chk #(
  .IDLE_CYCLES(IDLE_CYCLES), .REFRESH_CYCLES(REFRESH_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .set_o(set_o), .rst_o(rst_o),
  .level_q(level_q), .sync_q(sync_q)
);

// File: tb/edge_pulse_tx_tb.sv
module edge_pulse_tx_tb;
  localparam int S    = 2;
  localparam int G    = 4;
  localparam int IDLE = 100;
  localparam int PER  = 85;
  localparam int LAT  = S + G;

  typedef struct {
    int    at;
    logic  lvl;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic set_o, rst_o;
  int   cyc = -1;
  int   checks = 0;
  int   errors = 0;
  exp_t q[$];
  logic model_lvl = 1'b0;
  int   next_ref = 0;
  bit   first_ref = 1'b1;

  always #4 clk = ~clk;

  edge_pulse_tx #(
    .SYNC_STAGES(S), .GLITCH_CYCLES(G), .IDLE_CYCLES(IDLE), .REFRESH_CYCLES(PER)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .din_i(din), .set_o(set_o), .rst_o(rst_o)
  );

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : -1;

  function automatic void push(int at, logic lvl, string req);
    exp_t e;
    e.at = at; e.lvl = lvl; e.req = req;
    q.push_back(e);
  endfunction

  // Queue every refresh due strictly before cycle 'upto' (R6 first, then R7).
  function automatic void fill_refresh(int upto);
    while (next_ref < upto) begin
      push(next_ref, model_lvl, first_ref ? "R6" : "R7");
      first_ref = 1'b0;
      next_ref += PER;
    end
  endfunction

  // Drive level v for 'hold' sampling edges; queue the pulses it must cause.
  task automatic drive_level(logic v, int hold, string req);
    int c;
    int e;
    @(negedge clk);
    c   = cyc;
    din = v;
    if (v != model_lvl && hold >= G) begin
      e = c + LAT;
      fill_refresh(e);
      push(e, v, req);
      model_lvl = v;
      next_ref  = e + IDLE;
      first_ref = 1'b1;
    end
    fill_refresh(c + hold + LAT);
    repeat (hold - 1) @(negedge clk);
  endtask

  // Monitor: compare every cycle where a pulse is expected or seen.
  always @(negedge clk) begin
    if (rst_n && cyc >= 0) begin
      logic  exp_set, exp_clr;
      string req;
      exp_set = 1'b0; exp_clr = 1'b0; req = "R9";
      while (q.size() > 0 && q[0].at < cyc) begin
        checks++; errors++;
        $display("FAIL %s missed pulse due at cycle %0d: actual none expected level %b",
                 q[0].req, q[0].at, q[0].lvl);
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].at == cyc) begin
        exp_set = q[0].lvl;
        exp_clr = !q[0].lvl;
        req     = q[0].req;
        void'(q.pop_front());
      end
      if (exp_set || exp_clr || set_o || rst_o) begin
        checks++;
        if (set_o !== exp_set || rst_o !== exp_clr) begin
          errors++;
          $display("FAIL %s cycle %0d set/rst actual %b%b expected %b%b",
                   req, cyc, set_o, rst_o, exp_set, exp_clr);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    checks++;
    if (set_o !== 1'b0 || rst_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 during reset set/rst actual %b%b expected 00", set_o, rst_o);
    end
    push(0, 1'b0, "R1");
    next_ref  = IDLE;
    first_ref = 1'b1;
    rst_n = 1'b1;
    drive_level(1'b0, 150, "R7");
    drive_level(1'b1, G - 1, "R4");
    drive_level(1'b0, 40, "R4");
    drive_level(1'b1, G, "R5");
    drive_level(1'b0, IDLE, "R3");
    drive_level(1'b1, 250, "R8");
    drive_level(1'b0, G - 1, "R4");
    drive_level(1'b1, 50, "R4");
    drive_level(1'b0, 300, "R3");
    drive_level(1'b1, 120, "R2");
    repeat (LAT + 2) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R7 pending expected pulses actual %0d expected 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule